// File: doc/BRIEF.md
# Hall-driven six-step commutation controller

This block turns one PWM input and three rotor-position state inputs into the six gate enables of a three-phase brushless motor bridge. Each phase has a high-side enable and a low-side enable, and these go on to a separate dead-time stage. The state inputs can come straight from Hall sensors. They are decoded through a stored table. Code 000 stops the bridge. Code 111 aligns the rotor. The six remaining codes each select one drive step. In each drive step, one phase sources the PWM, a second phase sinks current through its low side, and the third phase floats.

A direction input reverses the rotation by swapping to a mirrored table. An active-low brake input overrides everything else: it turns every low side on and every high side off. A configuration bit chooses how the sourcing phase's low side behaves during the PWM off time. In synchronous rectification it follows inverted PWM. In diode freewheeling it stays off.

The state, direction and brake inputs pass through a two-flop synchronizer. The table read is registered, and the gate enables are registered. The PWM and configuration inputs are sampled only by the output register.

Top module: `sixstep_commutator`

## Requirements
- R1: While reset is high and on the first edges after it, every gate enable is 0 (Stop) until synchronized inputs reach the table.
- R2: State code 000 (bit 2 = phase A, bit 1 = B, bit 0 = C) turns all six gate enables off.
- R3: State code 111 gives phase A high = PWM and phase A low = inverted PWM, with the B and C low sides on and the B and C high sides off.
- R4: With dir_in = 0, the codes select these steps: 110 B→C, 100 A→C, 101 A→B, 001 C→B, 011 C→A, 010 B→A.
- R5: With dir_in = 1, the codes select these steps: 001 B→C, 011 A→C, 010 A→B, 110 C→B, 100 C→A, 101 B→A. Codes 000 and 111 behave as in R2 and R3.
- R6: In step X→Y, X high = PWM and X low = inverted PWM, Y low is on and Y high is off, and the third phase has both enables off. At most one high side is on at any time.
- R7: When brake_n = 0, all high sides are off and all low sides are on, whatever the other inputs are.
- R8: When async_rect = 1, the low side of the PWM-driven phase stays off instead of following inverted PWM.
- R9: A change on state_in, dir_in or brake_n reaches the gates on the fourth rising edge after it is sampled. A change on pwm_in or async_rect reaches the gates on the next rising edge.
- R10: A phase never has its high and low enables on at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM to apply to the sourcing phase |
| state_in | input | 3 | Position state, bit 2 = A, bit 1 = B, bit 0 = C |
| dir_in | input | 1 | Rotation direction select |
| brake_n | input | 1 | Active-low brake |
| async_rect | input | 1 | 1 = diode freewheeling, 0 = synchronous rectification |
| gate_hi | output | 3 | High-side enables, bit 0 = A, bit 1 = B, bit 2 = C |
| gate_lo | output | 3 | Low-side enables, bit 0 = A, bit 1 = B, bit 2 = C |

## Verification
The assertions check four things on every cycle:
- no phase has both enables on (shoot-through);
- at most one high side is on, and only when PWM was high on the previous edge;
- the bridge is quiet right after reset;
- a brake that has travelled through the pipeline forces all low sides on.

Other behaviours are shown only by the bench's scenarios, where its reference model compares every cycle. These are the exact step each code selects in both directions, the align pattern, the freewheeling choice, and the four-edge latency of the position inputs.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

  localparam int NUM_PHASE = 3;
  localparam int CODE_W    = 3;
  localparam int ADDR_W    = CODE_W + 1;
  localparam int ENTRY_W   = 2 * NUM_PHASE;

  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_PWM = 2'd1,
    DRV_LOW = 2'd2
  } drv_e;

  typedef logic [ENTRY_W-1:0] entry_t;

  localparam entry_t ENTRY_BRAKE = {DRV_LOW, DRV_LOW, DRV_LOW};

  // Table content for address {dir, code}; phase p occupies bits [2p+1:2p].
  function automatic entry_t step_entry(input logic [ADDR_W-1:0] addr);
    entry_t e;
    logic [CODE_W-1:0] c, k;
    int src, snk;
    e   = '0;
    c   = addr[CODE_W-1:0];
    k   = addr[CODE_W] ? ~c : c;
    src = -1;
    snk = -1;
    if (c == 3'b111) begin
      e = {DRV_LOW, DRV_LOW, DRV_PWM};
    end else if (c != 3'b000) begin
      case (k)
        3'b110:  begin src = 1; snk = 2; end
        3'b100:  begin src = 0; snk = 2; end
        3'b101:  begin src = 0; snk = 1; end
        3'b001:  begin src = 2; snk = 1; end
        3'b011:  begin src = 2; snk = 0; end
        3'b010:  begin src = 1; snk = 0; end
        default: begin src = -1; snk = -1; end
      endcase
      if (src >= 0) begin
        e[2*src +: 2] = DRV_PWM;
        e[2*snk +: 2] = DRV_LOW;
      end
    end
    return e;
  endfunction

endpackage

// File: rtl/sixstep_sync.sv
module sixstep_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sixstep_table.sv
module sixstep_table
  import sixstep_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              brake_act,
  output entry_t            entry_q
);

  localparam int DEPTH = 1 << ADDR_W;

  entry_t rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rom
    assign rom[a] = step_entry(ADDR_W'(a));
  end

  always_ff @(posedge clk) begin
    if (rst)            entry_q <= '0;
    else if (brake_act) entry_q <= ENTRY_BRAKE;
    else                entry_q <= rom[addr];
  end

endmodule

// File: rtl/sixstep_gate.sv
module sixstep_gate
  import sixstep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] drv,
  input  logic       pwm,
  input  logic       async_rect,
  output logic       hi,
  output logic       lo
);

  logic is_pwm, is_low;

  assign is_pwm = (drv == DRV_PWM);
  assign is_low = (drv == DRV_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= 1'b0;
      lo <= 1'b0;
    end else begin
      hi <= is_pwm & pwm;
      lo <= is_low | (is_pwm & ~pwm & ~async_rect);
    end
  end

endmodule

// File: rtl/sixstep_commutator.sv
module sixstep_commutator
  import sixstep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pwm_in,
  input  logic [CODE_W-1:0]    state_in,
  input  logic                 dir_in,
  input  logic                 brake_n,
  input  logic                 async_rect,
  output logic [NUM_PHASE-1:0] gate_hi,
  output logic [NUM_PHASE-1:0] gate_lo
);

  localparam int SYNC_W = CODE_W + 2;

  logic [SYNC_W-1:0] raw_in, sync_out;
  logic [CODE_W-1:0] code_s;
  logic              dir_s, brake_n_s;
  entry_t            entry_q;

  assign raw_in = {brake_n, dir_in, state_in};

  sixstep_sync #(
    .W      (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({1'b1, 1'b0, {CODE_W{1'b0}}})
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_out)
  );

  assign code_s    = sync_out[CODE_W-1:0];
  assign dir_s     = sync_out[CODE_W];
  assign brake_n_s = sync_out[CODE_W+1];

  sixstep_table u_table (
    .clk      (clk),
    .rst      (rst),
    .addr     ({dir_s, code_s}),
    .brake_act(~brake_n_s),
    .entry_q  (entry_q)
  );

  for (genvar p = 0; p < NUM_PHASE; p++) begin : g_phase
    sixstep_gate u_gate (
      .clk       (clk),
      .rst       (rst),
      .drv       (entry_q[2*p +: 2]),
      .pwm       (pwm_in),
      .async_rect(async_rect),
      .hi        (gate_hi[p]),
      .lo        (gate_lo[p])
    );
  end

endmodule

// File: rtl/sixstep_commutator_chk.sv
module sixstep_commutator_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwm_in,
  input logic       brake_n,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo
);

  logic [2:0] age;

  always_ff @(posedge clk) begin
    if (rst)           age <= '0;
    else if (age != 7) age <= age + 3'd1;
  end

  p_no_shoot_r10: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == 3'b000);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    (age == 0) |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  p_single_high_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(gate_hi) <= 1);

  p_high_follows_pwm_r6: assert property (@(posedge clk) disable iff (rst)
    (age >= 1 && gate_hi != 3'b000) |-> $past(pwm_in));

  p_brake_forces_low_r7: assert property (@(posedge clk) disable iff (rst)
    (age >= 5 && !$past(brake_n, 4)) |-> (gate_lo == 3'b111 && gate_hi == 3'b000));

endmodule

bind sixstep_commutator sixstep_commutator_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .pwm_in (pwm_in),
  .brake_n(brake_n),
  .gate_hi(gate_hi),
  .gate_lo(gate_lo)
);

// File: tb/tb_sixstep_commutator.sv
module tb_sixstep_commutator;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_in = 1'b0;
  logic [2:0] state_in = 3'b000;
  logic       dir_in = 1'b0;
  logic       brake_n = 1'b1;
  logic       async_rect = 1'b0;
  logic [2:0] gate_hi, gate_lo;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit done = 0;

  logic [2:0] exp_hi = 3'b000, exp_lo = 3'b000;
  string      exp_tag = "R1";
  logic [4:0] hist [$];

  always #2.5 clk = ~clk;

  sixstep_commutator dut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .state_in(state_in),
    .dir_in(dir_in), .brake_n(brake_n), .async_rect(async_rect),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // Behavioural model of requirements R2..R8
  task automatic model(input logic [2:0] st, input logic d, input logic bn,
                       input logic pwm, input logic as,
                       output logic [2:0] hi, output logic [2:0] lo,
                       output string tag);
    int src, snk;
    hi = 3'b000; lo = 3'b000; src = -1; snk = -1;
    if (!bn) begin
      lo = 3'b111; tag = "R7";
      return;
    end
    if (st == 3'b000) begin
      tag = "R2";
      return;
    end
    if (st == 3'b111) begin
      src = 0; tag = "R3";
      lo[1] = 1'b1; lo[2] = 1'b1;
    end else if (!d) begin
      tag = "R4";
      if (st == 3'b110) begin src = 1; snk = 2; end
      if (st == 3'b100) begin src = 0; snk = 2; end
      if (st == 3'b101) begin src = 0; snk = 1; end
      if (st == 3'b001) begin src = 2; snk = 1; end
      if (st == 3'b011) begin src = 2; snk = 0; end
      if (st == 3'b010) begin src = 1; snk = 0; end
    end else begin
      tag = "R5";
      if (st == 3'b001) begin src = 1; snk = 2; end
      if (st == 3'b011) begin src = 0; snk = 2; end
      if (st == 3'b010) begin src = 0; snk = 1; end
      if (st == 3'b110) begin src = 2; snk = 1; end
      if (st == 3'b100) begin src = 2; snk = 0; end
      if (st == 3'b101) begin src = 1; snk = 0; end
    end
    if (snk >= 0) lo[snk] = 1'b1;
    if (src >= 0) begin
      hi[src] = pwm;
      lo[src] = ~pwm & ~as;
      if (as) tag = {tag, "/R8"};
      else    tag = {tag, "/R6"};
    end
  endtask

  // Position inputs arrive after three stages, PWM and mode after one (R9)
  always @(posedge clk) begin
    logic [4:0] old;
    started <= 1'b1;
    if (rst) begin
      hist = {5'b10000, 5'b10000, 5'b10000};
      exp_hi <= 3'b000; exp_lo <= 3'b000; exp_tag <= "R1";
    end else begin
      logic [2:0] h, l;
      string t;
      hist.push_back({brake_n, dir_in, state_in});
      old = hist.pop_front();
      model(old[2:0], old[3], old[4], pwm_in, async_rect, h, l, t);
      exp_hi <= h; exp_lo <= l; exp_tag <= {t, "/R9"};
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      total++;
      if (gate_hi !== exp_hi || gate_lo !== exp_lo) begin
        bad++;
        $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", exp_tag,
                 gate_hi, gate_lo, exp_hi, exp_lo);
      end
      total++;
      if ((gate_hi & gate_lo) !== 3'b000) begin
        bad++;
        $display("FAIL R10: hi=%b lo=%b expected no overlap", gate_hi, gate_lo);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pwm_in = ~pwm_in;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    total++;
    if (gate_hi !== 3'b000 || gate_lo !== 3'b000) begin
      bad++;
      $display("FAIL R1: hi=%b lo=%b expected hi=000 lo=000", gate_hi, gate_lo);
    end
    rst = 1'b0;
    // sweep every code in both directions, both rectification modes
    for (int as = 0; as < 2; as++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 8; c++) begin
          @(negedge clk);
          async_rect = as[0]; dir_in = d[0]; state_in = c[2:0];
          step(9);
        end
    // brake pulses over live drive steps
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      state_in = 3'(k + 1); brake_n = 1'b0;
      step(k + 1);
      @(negedge clk);
      brake_n = 1'b1;
      step(6);
    end
    // mid-run reset
    @(negedge clk);
    state_in = 3'b101; rst = 1'b1;
    step(3);
    @(negedge clk);
    rst = 1'b0;
    step(8);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      pwm_in = 1'($urandom);
      if (($urandom % 4) == 0) state_in = 3'($urandom);
      if (($urandom % 16) == 0) dir_in = ~dir_in;
      if (($urandom % 32) == 0) brake_n = ~brake_n;
      if (($urandom % 64) == 0) async_rect = ~async_rect;
    end
    step(6);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule